// File: doc/BRIEF.md
# Cascadable Presettable Binary Up-Counter

This block is a synchronous binary up-counter, four bits wide by default, with the control set needed to build wider counters from identical slices. On each rising clock edge it either zeroes its state, takes a parallel value, advances by one, or keeps its value. Which of these happens is decided by a fixed priority across two active-low controls and two active-high count enables.

The two enables have different jobs. One of them, the chain enable, also qualifies the carry output. The other, the parallel enable, only gates counting. In a cascade, every slice shares the clock and the parallel enable. The carry output of each slice drives the chain enable of the next, more significant slice, so that slice advances only on the edge where every lower slice is about to wrap.

The carry output is combinational from the state and the chain enable, so a cascade settles within the same cycle. An active-low asynchronous reset sets the state to zero.

Top module: `sync_cascade_counter`

## Requirements
- R1: While `rst_n` is 0 the state `count` is 0 and `carry_out` is 0.
- R2: When `clear_n` is 0 at a rising edge, `count` becomes 0 after that edge.
- R3: When `clear_n` and `load_n` are both 0 at a rising edge, clear wins and `count` becomes 0; `load_val` has no effect.
- R4: When `clear_n` is 1 and `load_n` is 0 at a rising edge, `count` takes the value of `load_val` (bit i of `load_val` to bit i of `count`).
- R5: When `clear_n`, `load_n`, `en_par` and `en_chain` are all 1 at a rising edge, `count` increases by one modulo 2^WIDTH, so all ones wraps to 0.
- R6: When `clear_n` and `load_n` are 1 and either `en_par` or `en_chain` is 0 at a rising edge, `count` keeps its value.
- R7: `carry_out` is 1 exactly when `en_chain` is 1 and `count` is all ones; `en_par` has no effect on it.
- R8: Clear and load take effect whatever the values of `en_par` and `en_chain`.
- R9: On a counting edge, bit i of `count` (i > 0) changes only if all bits below i are 1; bit 0 changes on every counting edge.
- R10: Two slices joined carry-to-chain-enable, with a shared clock and parallel enable, behave as one 2·WIDTH-bit counter: they count through all 256 values in order, hold, wrap, clear and load, and the upper carry marks the all-ones state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by all state bits |
| rst_n | input | 1 | Active-low asynchronous power-on reset to zero |
| clear_n | input | 1 | Active-low synchronous clear, highest priority |
| load_n | input | 1 | Active-low synchronous parallel load |
| en_par | input | 1 | Count enable that gates counting only |
| en_chain | input | 1 | Count enable that also qualifies the carry |
| load_val | input | WIDTH | Value taken on a load |
| count | output | WIDTH | Counter state |
| carry_out | output | 1 | High when en_chain is high and count is all ones |

## Verification
The clear and load controls can both be asserted in the same cycle. The bench provokes this on purpose, with a load value far from zero and with the count enables both on and off. After the edge it expects zero, never the load value. Load also meets counting when both enables are high. There the bench expects the loaded value and not an increment, and its reference model settles every random mix of the four controls by the same priority order.

// File: rtl/scc_pkg.sv
package scc_pkg;

  typedef enum logic [1:0] {
    OP_CLEAR = 2'd0,
    OP_LOAD  = 2'd1,
    OP_COUNT = 2'd2,
    OP_HOLD  = 2'd3
  } scc_op_e;

  // priority: clear, then load, then count, else hold
  function automatic scc_op_e pick_op(input logic clr_n, input logic ld_n,
                                      input logic ep, input logic et);
    if (!clr_n)          return OP_CLEAR;
    else if (!ld_n)      return OP_LOAD;
    else if (ep && et)   return OP_COUNT;
    else                 return OP_HOLD;
  endfunction

endpackage

// File: rtl/scc_ctrl.sv
module scc_ctrl
  import scc_pkg::*;
(
  input  logic    clear_n,
  input  logic    load_n,
  input  logic    en_par,
  input  logic    en_chain,
  output scc_op_e op
);

  always_comb op = pick_op(clear_n, load_n, en_par, en_chain);

endmodule

// File: rtl/scc_next.sv
module scc_next
  import scc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  scc_op_e          op,
  input  logic [WIDTH-1:0] q,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] nxt
);

  logic             cnt;
  logic [WIDTH-1:0] low_ones;  // all bits below i are one
  logic [WIDTH-1:0] tog;       // bit i flips this edge
  logic [WIDTH-1:0] stepped;

  assign cnt = (op == OP_COUNT);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign low_ones[i] = 1'b1;
    end else begin : g_up
      assign low_ones[i] = low_ones[i-1] & q[i-1];
    end
    assign tog[i]     = cnt & low_ones[i];
    assign stepped[i] = q[i] ^ tog[i];
  end

  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = '0;
      OP_LOAD:  nxt = d;
      OP_COUNT: nxt = stepped;
      default:  nxt = q;
    endcase
  end

endmodule

// File: rtl/scc_carry.sv
module scc_carry #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             en_chain,
  output logic             carry
);

  function automatic logic is_top(input logic [WIDTH-1:0] v);
    return &v;
  endfunction

  assign carry = en_chain & is_top(q);

endmodule

// File: rtl/sync_cascade_counter.sv
module sync_cascade_counter
  import scc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_n,
  input  logic             load_n,
  input  logic             en_par,
  input  logic             en_chain,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] count,
  output logic             carry_out
);

  scc_op_e          op;
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;

  scc_ctrl u_ctrl (
    .clear_n  (clear_n),
    .load_n   (load_n),
    .en_par   (en_par),
    .en_chain (en_chain),
    .op       (op)
  );

  scc_next #(.WIDTH(WIDTH)) u_next (
    .op  (op),
    .q   (state_q),
    .d   (load_val),
    .nxt (state_d)
  );

  scc_carry #(.WIDTH(WIDTH)) u_carry (
    .q        (state_q),
    .en_chain (en_chain),
    .carry    (carry_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

  assign count = state_q;

endmodule

// File: rtl/scc_checker.sv
module scc_checker #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clear_n,
  input logic         load_n,
  input logic         en_par,
  input logic         en_chain,
  input logic [W-1:0] load_val,
  input logic [W-1:0] count,
  input logic         carry_out
);

  a_r1_reset_zero: assert property (@(posedge clk) !rst_n |-> (count == '0 && !carry_out));

  a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_n |=> count == '0);

  a_r3_clear_over_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_n && !load_n && load_val != '0) |=> count == '0);

  a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && !load_n) |=> count == $past(load_val));

  a_r5_count: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && load_n && en_par && en_chain) |=> count == W'($past(count) + 1'b1));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && load_n && !(en_par && en_chain)) |=> $stable(count));

  a_r7_carry_needs_top: assert property (@(posedge clk) disable iff (!rst_n)
    carry_out |-> (en_chain && (&count)));

  a_r7_top_gives_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (en_chain && (&count)) |-> carry_out);

  for (genvar i = 1; i < W; i++) begin : g_tog
    a_r9_upper_bit_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_n && load_n && en_par && en_chain && !(&count[i-1:0])) |=> $stable(count[i]));
  end

endmodule

bind sync_cascade_counter scc_checker #(.W(WIDTH)) u_scc_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clear_n   (clear_n),
  .load_n    (load_n),
  .en_par    (en_par),
  .en_chain  (en_chain),
  .load_val  (load_val),
  .count     (count),
  .carry_out (carry_out)
);

// File: tb/sync_cascade_counter_tb_top.sv
`timescale 1ns/1ps
module sync_cascade_counter_tb_top;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // single slice
  logic       rst_n = 1'b0;
  logic       clr_n = 1'b1, ld_n = 1'b1, ep = 1'b0, et = 1'b0;
  logic [3:0] din = '0;
  logic [3:0] q;
  logic       co;

  sync_cascade_counter #(.WIDTH(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .clear_n(clr_n), .load_n(ld_n),
    .en_par(ep), .en_chain(et), .load_val(din), .count(q), .carry_out(co)
  );

  // two-slice cascade
  logic       c_clr_n = 1'b1, c_ld_n = 1'b1, c_ep = 1'b0, c_et = 1'b0;
  logic [7:0] c_din = '0;
  logic [3:0] lo_q, hi_q;
  logic       lo_co, hi_co;

  sync_cascade_counter #(.WIDTH(4)) casc_lo_i (
    .clk(clk), .rst_n(rst_n), .clear_n(c_clr_n), .load_n(c_ld_n),
    .en_par(c_ep), .en_chain(c_et), .load_val(c_din[3:0]), .count(lo_q), .carry_out(lo_co)
  );
  sync_cascade_counter #(.WIDTH(4)) casc_hi_i (
    .clk(clk), .rst_n(rst_n), .clear_n(c_clr_n), .load_n(c_ld_n),
    .en_par(c_ep), .en_chain(lo_co), .load_val(c_din[7:4]), .count(hi_q), .carry_out(hi_co)
  );

  int m_q = 0;   // reference model, single slice
  int c_m = 0;   // reference model, whole cascade

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // one edge for both models, then compare at the falling edge
  task automatic tick(string req);
    int carry_exp;
    @(posedge clk);
    if (!clr_n)        m_q = 0;
    else if (!ld_n)    m_q = int'(din);
    else if (ep && et) m_q = (m_q + 1) % 16;
    if (!c_clr_n)          c_m = 0;
    else if (!c_ld_n)      c_m = int'(c_din);
    else if (c_ep && c_et) c_m = (c_m + 1) % 256;
    @(negedge clk);
    chk(req, int'(q), m_q);
    carry_exp = (et && m_q == 15) ? 1 : 0;
    chk({req, " carry(R7)"}, int'(co), carry_exp);
  endtask

  task automatic tick_casc(string req);
    tick(req);
    chk({req, " cascade(R10)"}, int'({hi_q, lo_q}), c_m);
    chk("R10 upper carry", int'(hi_co), (c_et && c_m == 255) ? 1 : 0);
  endtask

  function automatic string req_of(logic c, logic l, logic p, logic t);
    if (!c && !l) return "R3";
    if (!c)       return "R2";
    if (!l)       return "R4";
    if (p && t)   return "R5";
    return "R6";
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin : stim
    // R1 reset state
    repeat (3) @(negedge clk);
    et = 1'b1;
    #1;
    chk("R1 count in reset", int'(q), 0);
    chk("R1 carry in reset", int'(co), 0);
    rst_n = 1'b1;
    et = 1'b0;
    @(negedge clk);

    // R4 + R8: load with enables off
    din = 4'hA; ld_n = 1'b0; tick("R4 load, R8 enables off");
    chk("R4 loaded value", int'(q), 10);
    ld_n = 1'b1;
    tick("R6 hold both enables off");

    // load beats counting
    din = 4'h3; ld_n = 1'b0; ep = 1'b1; et = 1'b1; tick("R4 load over count");
    chk("R4 load over count", int'(q), 3);
    ld_n = 1'b1;

    // R9: 3 -> 4 -> 5 -> 6 -> 7 -> 8 crosses several carries
    for (int k = 0; k < 5; k++) tick("R9 toggle rule");
    chk("R9 0111->1000", int'(q), 8);

    // R5 wrap and R7 carry
    din = 4'hD; ld_n = 1'b0; tick("R4"); ld_n = 1'b1;
    tick("R5 D->E"); tick("R5 E->F");
    chk("R7 carry at all ones", int'(co), 1);
    ep = 1'b0; #1;
    chk("R7 en_par has no effect", int'(co), 1);
    tick("R6 hold en_par low");
    et = 1'b0; #1;
    chk("R7 carry off when en_chain low", int'(co), 0);
    ep = 1'b1; tick("R6 hold en_chain low");
    et = 1'b1; tick("R5 wrap F->0");
    chk("R5 wrapped", int'(q), 0);

    // R3: clear and load together, with and without enables
    din = 4'hB; ld_n = 1'b0; tick("R4"); // q = B
    clr_n = 1'b0; din = 4'h9; tick("R3 clear beats load");
    chk("R3 zero not load", int'(q), 0);
    ep = 1'b0; et = 1'b0; din = 4'h6; ld_n = 1'b1; clr_n = 1'b1; ld_n = 1'b0; tick("R4");
    clr_n = 1'b0; tick("R3 R8 clear over load, enables off");
    ld_n = 1'b1; din = 4'h5; clr_n = 1'b1; ld_n = 1'b0; tick("R4"); ld_n = 1'b1;
    clr_n = 1'b0; tick("R2 clear alone"); clr_n = 1'b1;

    // mixed controls
    for (int k = 0; k < 400; k++) begin
      clr_n = ($urandom % 8) != 0;
      ld_n  = ($urandom % 6) != 0;
      ep    = ($urandom % 4) != 0;
      et    = ($urandom % 4) != 0;
      din   = 4'($urandom);
      tick(req_of(clr_n, ld_n, ep, et));
    end
    clr_n = 1'b1; ld_n = 1'b1; ep = 1'b0; et = 1'b0;

    // R10 cascade
    c_clr_n = 1'b0; tick_casc("R10 clear"); c_clr_n = 1'b1;
    c_ep = 1'b1; c_et = 1'b1;
    for (int k = 0; k < 260; k++) tick_casc("R10 count");
    c_din = 8'h0F; c_ld_n = 1'b0; tick_casc("R10 load"); c_ld_n = 1'b1;
    c_ep = 1'b0; #1;
    chk("R10 low carry with en_par low", int'(lo_co), 1);
    tick_casc("R10 hold via en_par");
    c_ep = 1'b1; c_et = 1'b0; tick_casc("R10 hold via chain enable");
    c_et = 1'b1; tick_casc("R10 0x0F->0x10");
    c_din = 8'hFE; c_ld_n = 1'b0; tick_casc("R10 load FE"); c_ld_n = 1'b1;
    tick_casc("R10 to FF"); tick_casc("R10 wrap");
    c_clr_n = 1'b0; c_ld_n = 1'b0; tick_casc("R10 R3 clear over load");
    c_clr_n = 1'b1; c_ld_n = 1'b1;

    done = 1;
    summary();
    $finish;
  end

endmodule